// File: doc/BRIEF.md
# Triggered One-Pulse Timer

This block is a 16-bit timer channel that stays idle until an external trigger shows its active edge. It then counts prescaled ticks and drives a single output. The output turns active after a programmable delay and returns to its idle level at a programmable end point. In single mode the counter stops by itself at the next update event, so each trigger gives exactly one pulse. In repetitive mode the counter keeps cycling and the output becomes a continuous waveform with the same phase.

The compare value sets where the output turns active, and the reload value sets where it ends. The period register is the reload value plus one tick. Either register can be used directly or through a shadow copy. A shadow copy only takes a new value on an update event, which is either a counter rollover or a software update strobe. The counter can count up or down, the output level can be inverted, and the trigger edge can be chosen as rising or falling.

Top module: `onepulse_timer`

## Requirements
- R1: After reset, `running` is 0 and `pulse_out` equals `out_invert`.
- R2: The trigger passes through a two-flop synchronizer. When `trig_falling`=0 the active edge is 0→1, and when it is 1 the active edge is 1→0. If the active level is applied between clock edges, `running` is 1 after the third rising clock edge that follows.
- R3: The tick enable comes from a prescaler that divides the clock by `psc_div`+1. When counting up (`count_down`=0), the counter starts at 0 and the output turns active `cmp_val`×(`psc_div`+1) clocks after `running` rises.
- R4: When counting up, the output is active while compare ≤ count < reload. The pulse therefore lasts (reload − compare) ticks and ends when the count reaches the reload value.
- R5: When `single_mode`=1, `running` falls at the rollover, (reload+1)×(`psc_div`+1) clocks after it rose, and the output goes back to its idle level.
- R6: When `single_mode`=0, counting repeats with a period of (reload+1)×(`psc_div`+1) clocks. If `single_mode` is set while the counter is running, it stops at the next rollover.
- R7: When counting down, the counter starts from the reload value and the output is active while 0 < count ≤ compare. The delay is (reload − compare) ticks, the width is compare ticks, and the run stops when the counter underflows below 0, after reload+1 ticks in total.
- R8: `pulse_out` is the active-high waveform XORed with `out_invert`.
- R9: When `cmp_preload` or `arr_preload` is 1, the matching register only takes `cmp_val` or `arr_val` on an update event (rollover or `sw_update`). When the bit is 0, the port value takes effect at once.
- R10: A one-clock `sw_update` sets the counter to 0 (up) or to `arr_val` (down), clears the prescaler and loads both shadows. It does not start the counter, and during a run it restarts the count from that point.
- R11: An active trigger edge that arrives while `running`=1 is ignored, so the timing of the run does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger input |
| trig_falling | input | 1 | 1 selects the falling edge as active |
| single_mode | input | 1 | 1 stops the counter at the next rollover |
| count_down | input | 1 | 1 selects down-counting |
| cmp_preload | input | 1 | Compare value goes through a shadow register |
| arr_preload | input | 1 | Reload value goes through a shadow register |
| out_invert | input | 1 | Inverts the output level |
| sw_update | input | 1 | One-clock software update strobe |
| psc_div | input | 16 | Prescaler divide value minus one |
| cmp_val | input | 16 | Compare value |
| arr_val | input | 16 | Reload value |
| pulse_out | output | 1 | Pulse output |
| running | output | 1 | Counter enable |

## Verification
The hardest cases to reach from the ports are the ones where something happens in the middle of a run. These include a second trigger edge while the counter is running, a software update partway through the count, and a shadowed compare value that changes between the arming update and the rollover. The bench first measures when `running` rises. It then schedules the second edge or the strobe a fixed number of cycles after that point, so the expected delay, width and run length are all known in closed form. It also sweeps every legal compare value for small reload values, for several prescaler settings, in both directions and with both polarities and trigger edges.

// File: rtl/op_pkg.sv
// Shared definitions for the one-pulse timer.
// Assumes: counter and prescaler widths are fixed by the top's parameters.
package op_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } count_dir_e;
endpackage

// File: rtl/op_edge_detect.sv
// Synchronizes an asynchronous trigger and emits a one-clock pulse on the
// selected edge.
// Assumes: sel_falling stays constant around an edge.
module op_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic sel_falling,
    output logic edge_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the trigger through the synchronizer flops.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= sig_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Pick the edge polarity.
    always_comb begin
        if (sel_falling) edge_pulse = prev_q & ~sync_q[SYNC_STAGES-1];
        else             edge_pulse = ~prev_q & sync_q[SYNC_STAGES-1];
    end

    a_r2_one_clock_start: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse && $stable(sel_falling) |=> !edge_pulse);
endmodule

// File: rtl/op_prescaler.sv
// Divides the clock by div+1 while run is high and produces the tick enable.
// Assumes: clear has priority and returns the divider to phase zero.
module op_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] psc_q;

    assign tick = run && (psc_q >= div);

    // Count clocks between ticks, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     psc_q <= '0;
        else if (clear) psc_q <= '0;
        else if (run)   psc_q <= tick ? '0 : psc_q + 1'b1;
    end

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/op_counter.sv
// Up/down counter with a shadowed reload value, run enable and update event.
// Assumes: start is a one-clock pulse; in down mode the counter is armed
// above the compare value by a software update.
module op_counter
    import op_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sw_update,
    input  logic             tick,
    input  logic             single,
    input  count_dir_e       dir,
    input  logic             arr_pre,
    input  logic [CNT_W-1:0] cfg_arr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_eff,
    output logic             running,
    output logic             update_ev
);
    logic [CNT_W-1:0] arr_sh_q;
    logic             rollover;

    assign rollover  = tick && ((dir == DIR_DOWN) ? (cnt == '0) : (cnt >= arr_eff));
    assign update_ev = rollover || sw_update;
    assign arr_eff   = arr_pre ? arr_sh_q : cfg_arr;

    // Load the reload shadow on each update event.
    always_ff @(posedge clk) begin
        if (!rst_n)         arr_sh_q <= '0;
        else if (update_ev) arr_sh_q <= cfg_arr;
    end

    // Advance, wrap or rearm the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (sw_update)      cnt <= (dir == DIR_DOWN) ? cfg_arr : '0;
        else if (rollover)       cnt <= (dir == DIR_DOWN) ? cfg_arr : '0;
        else if (tick)           cnt <= (dir == DIR_DOWN) ? cnt - 1'b1 : cnt + 1'b1;
    end

    // Start on a trigger, stop at a rollover in single mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  running <= 1'b0;
        else if (rollover && single) running <= 1'b0;
        else if (start)              running <= 1'b1;
    end

    a_r11_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(start));
    a_r5_stop_at_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(rollover && single));
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !sw_update |=> $stable(cnt));
    a_r9_arr_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update_ev |=> $stable(arr_sh_q));
endmodule

// File: rtl/op_wave.sv
// Holds the compare shadow and forms the output waveform from the count.
// Assumes: the output is idle whenever the counter is not running.
module op_wave
    import op_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             cmp_pre,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] arr_eff,
    input  logic             running,
    input  count_dir_e       dir,
    input  logic             invert,
    output logic             wave_out
);
    logic [CNT_W-1:0] cmp_sh_q;
    logic [CNT_W-1:0] cmp_eff;
    logic             active;

    assign cmp_eff = cmp_pre ? cmp_sh_q : cfg_cmp;

    // Load the compare shadow on each update event.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmp_sh_q <= '0;
        else if (load) cmp_sh_q <= cfg_cmp;
    end

    // Decide whether the count lies inside the active window.
    always_comb begin
        if (dir == DIR_DOWN) active = (cnt <= cmp_eff) && (cnt != '0);
        else                 active = (cnt >= cmp_eff) && (cnt < arr_eff);
    end

    assign wave_out = (running & active) ^ invert;

    a_r9_cmp_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmp_sh_q));
endmodule

// File: rtl/onepulse_timer.sv
// Triggered one-pulse timer: a synchronized edge starts a prescaled
// counter whose compare and reload values set the pulse's delay and end.
// Assumes: software arms the counter with sw_update before triggering.
module onepulse_timer
    import op_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             trig_falling,
    input  logic             single_mode,
    input  logic             count_down,
    input  logic             cmp_preload,
    input  logic             arr_preload,
    input  logic             out_invert,
    input  logic             sw_update,
    input  logic [PSC_W-1:0] psc_div,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] arr_val,
    output logic             pulse_out,
    output logic             running
);
    count_dir_e       dir;
    logic             start;
    logic             tick;
    logic             update_ev;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] arr_eff;

    assign dir = count_down ? DIR_DOWN : DIR_UP;

    op_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(trig_in),
        .sel_falling(trig_falling), .edge_pulse(start)
    );

    op_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(running), .clear(sw_update),
        .div(psc_div), .tick(tick)
    );

    op_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .sw_update(sw_update),
        .tick(tick), .single(single_mode), .dir(dir), .arr_pre(arr_preload),
        .cfg_arr(arr_val), .cnt(cnt), .arr_eff(arr_eff), .running(running),
        .update_ev(update_ev)
    );

    op_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .load(update_ev), .cmp_pre(cmp_preload),
        .cfg_cmp(cmp_val), .cnt(cnt), .arr_eff(arr_eff), .running(running),
        .dir(dir), .invert(out_invert), .wave_out(pulse_out)
    );

    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pulse_out == out_invert));
    a_r4_ends_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
        running && !count_down && (cnt == arr_eff) |-> (pulse_out == out_invert));
    a_r10_update_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running && sw_update |=> !running);
endmodule

// File: tb/tb_onepulse_timer.sv
module tb_onepulse_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_falling = 1'b0;
    logic        single_mode = 1'b1;
    logic        count_down = 1'b0;
    logic        cmp_preload = 1'b0;
    logic        arr_preload = 1'b0;
    logic        out_invert = 1'b0;
    logic        sw_update = 1'b0;
    logic [15:0] psc_div = '0;
    logic [15:0] cmp_val = '0;
    logic [15:0] arr_val = '0;
    logic        pulse_out;
    logic        running;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    onepulse_timer dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_falling(trig_falling),
        .single_mode(single_mode), .count_down(count_down),
        .cmp_preload(cmp_preload), .arr_preload(arr_preload),
        .out_invert(out_invert), .sw_update(sw_update), .psc_div(psc_div),
        .cmp_val(cmp_val), .arr_val(arr_val), .pulse_out(pulse_out),
        .running(running)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Choose the edge and park the trigger at its idle level.
    task automatic set_edge(input bit falling);
        @(negedge clk);
        trig_falling = falling;
        repeat (2) @(negedge clk);
        trig_in = falling;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe_update();
        @(negedge clk) sw_update = 1'b1;
        @(negedge clk) sw_update = 1'b0;
    endtask

    // Fire one trigger and time running/output transitions relative to it.
    task automatic run_pulse(input bit do_swu, input int swu_at, input int retrig_at,
                             output int t0, output int d1, output int d2, output int d3);
        int t1, t2, t3;
        t0 = -1; t1 = -1; t2 = -1; t3 = -1;
        if (do_swu) strobe_update();
        repeat (3) @(negedge clk);
        trig_in = ~trig_falling;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            sw_update = 1'b0;
            if (t0 < 0 && running) t0 = k;
            else if (t0 >= 0 && t1 < 0 && (pulse_out ^ out_invert)) t1 = k;
            else if (t1 >= 0 && t2 < 0 && !(pulse_out ^ out_invert)) t2 = k;
            if (t0 >= 0 && t3 < 0 && !running) t3 = k;
            if (t0 >= 0 && swu_at > 0 && k == t0 + swu_at) sw_update = 1'b1;
            if (t0 >= 0 && retrig_at > 0 && k == t0 + retrig_at) trig_in = trig_falling;
            if (t0 >= 0 && retrig_at > 0 && k == t0 + retrig_at + 2) trig_in = ~trig_falling;
            if (t3 >= 0) break;
        end
        trig_in = trig_falling;
        repeat (4) @(negedge clk);
        d1 = t1 - t0; d2 = t2 - t1; d3 = t3 - t0;
    endtask

    initial begin
        while (cycles < 150000 && !done) @(negedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t0, d1, d2, d3, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 running after reset", running, 0);
        check("R1 output idle after reset", pulse_out, 0);

        // R10: an update alone does not start the counter
        arr_val = 16'd5; cmp_val = 16'd2;
        strobe_update();
        repeat (10) @(negedge clk);
        check("R10 update does not start", running, 0);
        check("R10 output idle after update", pulse_out, 0);

        // R2 R3 R4 R5 R7 R8: sweep direction, prescaler, reload, compare
        for (int dn = 0; dn < 2; dn++) begin
            for (int ps = 0; ps < 3; ps++) begin
                for (int ar = 2; ar < 6; ar++) begin
                    for (int cm = 1; cm < ar; cm++) begin
                        p = ps + 1;
                        set_edge(1'((ps + dn) % 2));
                        count_down = 1'(dn);
                        out_invert = 1'((ar + cm) % 2);
                        psc_div = 16'(ps);
                        arr_val = 16'(ar);
                        cmp_val = 16'(cm);
                        run_pulse(1'b1, 0, 0, t0, d1, d2, d3);
                        check("R2 trigger to running", t0, 3);
                        if (dn == 0) begin
                            check("R3 up delay", d1, cm * p);
                            check("R4 up width", d2, (ar - cm) * p);
                            check("R5 single run length", d3, (ar + 1) * p);
                        end else begin
                            check("R7 down delay", d1, (ar - cm) * p);
                            check("R7 down width", d2, cm * p);
                            check("R7 down run length", d3, (ar + 1) * p);
                        end
                        check("R8 idle level follows invert", pulse_out, out_invert);
                    end
                end
            end
        end

        // R11: second edge during a run is ignored
        set_edge(1'b0);
        count_down = 1'b0; out_invert = 1'b0; psc_div = '0;
        arr_val = 16'd6; cmp_val = 16'd2;
        run_pulse(1'b1, 0, 1, t0, d1, d2, d3);
        check("R11 retrigger delay unchanged", d1, 2);
        check("R11 retrigger length unchanged", d3, 7);
        repeat (6) @(negedge clk);
        check("R11 no restart after run", running, 0);

        // R10: update in mid-run restarts the count
        arr_val = 16'd5; cmp_val = 16'd3;
        run_pulse(1'b1, 2, 0, t0, d1, d2, d3);
        check("R10 mid-run update delay", d1, 6);
        check("R10 mid-run update width", d2, 2);
        check("R10 mid-run update length", d3, 9);

        // R9: compare shadow holds until an update
        cmp_preload = 1'b1; arr_preload = 1'b1;
        arr_val = 16'd5; cmp_val = 16'd2;
        strobe_update();
        cmp_val = 16'd4; arr_val = 16'd7;
        run_pulse(1'b0, 0, 0, t0, d1, d2, d3);
        check("R9 preloaded compare kept", d1, 2);
        check("R9 preloaded reload kept", d3, 6);
        run_pulse(1'b0, 0, 0, t0, d1, d2, d3);
        check("R9 shadow loaded at rollover delay", d1, 4);
        check("R9 shadow loaded at rollover length", d3, 8);
        cmp_preload = 1'b0; arr_preload = 1'b0;
        cmp_val = 16'd1;
        run_pulse(1'b0, 0, 0, t0, d1, d2, d3);
        check("R9 direct compare immediate", d1, 1);
        check("R9 direct reload width", d2, 6);

        // R6: repetitive mode period, then stop by setting single mode
        single_mode = 1'b0;
        arr_val = 16'd3; cmp_val = 16'd1; psc_div = 16'd1;
        strobe_update();
        @(negedge clk) trig_in = 1'b1;
        begin
            int r1, r2, prev;
            r1 = -1; r2 = -1; prev = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (pulse_out && !prev) begin
                    if (r1 < 0) r1 = k;
                    else if (r2 < 0) r2 = k;
                end
                prev = int'(pulse_out);
            end
            check("R6 repetitive period", r2 - r1, 8);
            check("R6 still running", running, 1);
        end
        single_mode = 1'b1;
        repeat (10) @(negedge clk);
        check("R6 stops after single set", running, 0);
        check("R6 output idle after stop", pulse_out, 0);
        trig_in = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule